// File: doc/BRIEF.md
# Multi-Channel Hierarchical Interrupt Aggregator

This block collects single-cycle event pulses from several framer channels into sticky, clear-on-read status registers. It reduces them to one shared interrupt request. Each channel owns a small set of status registers. Every status register has its own per-bit mask. It also has a summary ("vector") bit that shows whether the register holds any enabled bit. A per-register vector mask decides which summary bits may pull the shared request low. The request is modelled as a drive-low enable for an open-drain pad: `irq_drive_o = 1` means the line is pulled low, and `0` means it is released.

Each channel has two control bits. The first is a run bit: when it is clear, the channel's summary bits are forced to zero while its status still captures events. The second is a live bit: when it is clear, the channel's status is wiped and held empty. A global active-low initialization input holds every channel empty and keeps the line released, and it leaves all masks untouched. A processor reaches everything through a simple synchronous read/write port.

Address layout: `cpu_addr[AW-1:4]` selects the channel and `cpu_addr[3:0]` selects the offset within it:

- Offsets 0-3 are status registers 0-3.
- Offsets 4-7 are the per-bit masks of status registers 0-3.
- Offset 8 is the vector mask, with bit r for status register r.
- Offset 9 is control: bit0 is run, bit1 is live, and bit2 is a channel reset that is not stored.
- Offset 10 is the channel vector word, with bit r for status register r.

Top module: `irq_aggregator`

## Requirements
- R1: An event pulse on `evt_i[(c*NREG+r)*W+b]` sets bit b of status register r of channel c at that clock edge. The bit stays set until that register is read.
- R2: A read (`cpu_re`) returns the addressed register on `cpu_rdata` after the next edge. A status read clears the register at that edge. An event that arrives in the same cycle as the read survives the clear.
- R3: Vector bit r of a channel (offset 10, bit r) is 1 when status register r has any bit set whose mask bit is 1 and the channel's run bit is 1. Reading the vector word does not change it. A status bit whose mask bit is 0 is still captured.
- R4: `irq_drive_o` rises one edge after any vector bit that is enabled by its vector mask becomes 1. It stays 1 while any such bit remains. It falls one edge after the last one clears.
- R5: A vector-mask bit of 0 stops its vector bit from affecting `irq_drive_o`. The status register still captures events, and the vector word still reports the bit.
- R6: With run = 0, the channel's status registers still capture events and still clear on read. Its vector bits read 0, and it cannot raise `irq_drive_o`.
- R7: With live = 0, every status register of the channel is cleared and captures no events. Its vector bits read 0.
- R8: While `init_n` is 0, all status registers are cleared and not updated, and `irq_drive_o` is 0 from the next edge. Masks, vector masks and control bits keep their values.
- R9: After `rst_n` reset, every per-bit mask reads 8'hFF and every vector mask reads all ones. Run and live are 0, and `irq_drive_o` is 0. Writing control with bit2 = 1 does the same to that channel only, and also clears its status.
- R10: Masks, vector masks and control bits [1:0] read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_n | input | 1 | Global hold-clear, active low |
| evt_i | input | NCH*NREG*W | Event pulses, one per status bit |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | AW | Channel and offset |
| cpu_wdata | input | W | Write data |
| cpu_rdata | output | W | Read data, registered |
| irq_drive_o | output | 1 | 1 = pull the shared request line low |

## Verification
A status bit appears one edge after its event, and read data appears one edge after the read strobe. The vector word follows the status combinationally, so it is visible in the same cycle as the status. The request line reacts one edge later still, so it trails an event by two edges and trails a clearing read by one edge. The bench drives every input on the falling edge. It advances a reference model at the rising edge, built from the old state. It compares the request line and any read data 1 ns after that edge. Directed sequences check the request level both one edge and two edges after a stimulus, so that an extra or a missing register stage is seen.

// File: rtl/irq_aggr_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets and control layout of the interrupt aggregator.
// Assumes at most four status registers per channel (offsets 0-3, masks 4-7).
package irq_aggr_pkg;
    localparam int          OFS_W      = 4;
    localparam logic [3:0]  OFS_MASK   = 4'd4;
    localparam logic [3:0]  OFS_VMASK  = 4'd8;
    localparam logic [3:0]  OFS_CTRL   = 4'd9;
    localparam logic [3:0]  OFS_VEC    = 4'd10;
    localparam int          CTRL_RUN   = 0;
    localparam int          CTRL_LIVE  = 1;
    localparam int          CTRL_CHRST = 2;

    // Stored per-channel control bits
    typedef struct packed {
        logic live;   // 0 = status held empty
        logic run;    // 0 = vector bits forced low
    } chan_ctrl_t;
endpackage

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
// One sticky status register with its per-bit mask.
// Assumes: hold and chan_rst win over everything; an event in the same
// cycle as a read-clear is kept.
module irq_status_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         chan_rst,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         pend
);
    // Status capture with clear-on-read and hold-clear
    always_ff @(posedge clk) begin
        if (!rst_n)               status <= '0;
        else if (chan_rst || hold) status <= '0;
        else                       status <= (rd_clr ? '0 : status) | evt;
    end

    // Per-bit mask, all enabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n)        mask <= '1;
        else if (chan_rst) mask <= '1;
        else if (mask_we)  mask <= mask_wdata;
    end

    // Any enabled bit pending
    assign pend = |(status & mask);
endmodule

// File: rtl/irq_channel.sv
`timescale 1ns/1ps
// One channel: NREG status registers, vector mask, run/live control and
// the channel's local read mux. Assumes NREG <= 4 and W >= NREG.
module irq_channel
    import irq_aggr_pkg::*;
#(
    parameter int NREG = 4,
    parameter int W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic              sel,
    input  logic              we,
    input  logic              re,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [W-1:0]      wdata,
    input  logic [NREG*W-1:0] evt,
    output logic [W-1:0]      rdata,
    output logic [NREG-1:0]   vec,
    output logic [NREG-1:0]   vec_en,
    output logic              hold
);
    chan_ctrl_t        ctrl_q;
    logic [NREG-1:0]   vmask_q;
    logic [NREG-1:0]   pend;
    logic [W-1:0]      st_arr [NREG];
    logic [W-1:0]      mk_arr [NREG];
    logic              wr_ctrl;
    logic              wr_vmask;
    logic              chan_rst;

    assign wr_ctrl  = sel && we && (ofs == OFS_CTRL);
    assign wr_vmask = sel && we && (ofs == OFS_VMASK);
    assign chan_rst = wr_ctrl && wdata[CTRL_CHRST];
    assign hold     = !init_n || !ctrl_q.live;

    // Status registers of this channel
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic rd_clr_r;
        logic mask_we_r;
        assign rd_clr_r  = sel && re && (ofs == 4'(r));
        assign mask_we_r = sel && we && (ofs == OFS_MASK + 4'(r));
        irq_status_reg #(.W(W)) sreg_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold       (hold),
            .chan_rst   (chan_rst),
            .rd_clr     (rd_clr_r),
            .mask_we    (mask_we_r),
            .mask_wdata (wdata),
            .evt        (evt[r*W +: W]),
            .status     (st_arr[r]),
            .mask       (mk_arr[r]),
            .pend       (pend[r])
        );
    end

    // Control bits: cleared by reset and channel reset
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (chan_rst) ctrl_q <= '0;
        else if (wr_ctrl)  ctrl_q <= '{live: wdata[CTRL_LIVE], run: wdata[CTRL_RUN]};
    end

    // Vector mask: all enabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n)        vmask_q <= '1;
        else if (chan_rst) vmask_q <= '1;
        else if (wr_vmask) vmask_q <= wdata[NREG-1:0];
    end

    // Vector bits gated by run, then by the vector mask
    assign vec    = pend & {NREG{ctrl_q.run}};
    assign vec_en = vec & vmask_q;

    // Local read mux
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (ofs == 4'(r))            rdata = st_arr[r];
            if (ofs == OFS_MASK + 4'(r)) rdata = mk_arr[r];
        end
        if (ofs == OFS_VMASK) rdata = W'(vmask_q);
        if (ofs == OFS_CTRL)  rdata = W'({ctrl_q.live, ctrl_q.run});
        if (ofs == OFS_VEC)   rdata = W'(vec);
    end
endmodule

// File: rtl/irq_combine.sv
`timescale 1ns/1ps
// Reduces all enabled vector bits into the registered drive-low request.
// Assumes init_n low must release the line from the next edge.
module irq_combine #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_n,
    input  logic [N-1:0] vec_en,
    output logic         irq_q
);
    // Registered OR of enabled vector bits
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= init_n && (|vec_en);
    end
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
// Top: channel array, address decode, registered read data and the
// shared request. Assumes cpu_we and cpu_re are never high together.
module irq_aggregator
    import irq_aggr_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NREG = 4,
    parameter int W    = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW   = CH_W + OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_n,
    input  logic [NCH*NREG*W-1:0] evt_i,
    input  logic                  cpu_we,
    input  logic                  cpu_re,
    input  logic [AW-1:0]         cpu_addr,
    input  logic [W-1:0]          cpu_wdata,
    output logic [W-1:0]          cpu_rdata,
    output logic                  irq_drive_o
);
    localparam int NVEC = NCH * NREG;

    logic [CH_W-1:0]  ch_sel;
    logic [OFS_W-1:0] ofs;
    logic [W-1:0]     rdata_ch [NCH];
    logic [NVEC-1:0]  vec_all;
    logic [NVEC-1:0]  vec_en_all;
    logic [NCH-1:0]   hold_all;

    assign ch_sel = cpu_addr[AW-1:OFS_W];
    assign ofs    = cpu_addr[OFS_W-1:0];

    // Channel array
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        irq_channel #(.NREG(NREG), .W(W)) ch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .init_n (init_n),
            .sel    (ch_sel == CH_W'(c)),
            .we     (cpu_we),
            .re     (cpu_re),
            .ofs    (ofs),
            .wdata  (cpu_wdata),
            .evt    (evt_i[c*NREG*W +: NREG*W]),
            .rdata  (rdata_ch[c]),
            .vec    (vec_all[c*NREG +: NREG]),
            .vec_en (vec_en_all[c*NREG +: NREG]),
            .hold   (hold_all[c])
        );
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_rdata <= '0;
        else if (cpu_re) cpu_rdata <= rdata_ch[ch_sel];
    end

    // Shared request
    irq_combine #(.N(NVEC)) comb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_n (init_n),
        .vec_en (vec_en_all),
        .irq_q  (irq_drive_o)
    );
endmodule

// File: rtl/irq_aggr_checker.sv
`timescale 1ns/1ps
// Checker bound to irq_aggregator: request timing and hold-clear rules.
module irq_aggr_checker #(
    parameter int NCH  = 8,
    parameter int NREG = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                init_n,
    input logic                irq_drive_o,
    input logic [NCH*NREG-1:0] vec_all,
    input logic [NCH*NREG-1:0] vec_en_all,
    input logic [NCH-1:0]      hold_all
);
    assert_init_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |=> !irq_drive_o);

    assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive_o |-> $past((|vec_en_all) && init_n));

    assert_irq_sustain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|vec_en_all) && init_n) |=> irq_drive_o);

    assert_irq_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(irq_drive_o));

    for (genvar c = 0; c < NCH; c++) begin : g_hold
        assert_hold_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hold_all[c] |=> (vec_all[c*NREG +: NREG] == '0));
    end
endmodule

bind irq_aggregator irq_aggr_checker #(.NCH(NCH), .NREG(NREG)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_n      (init_n),
    .irq_drive_o (irq_drive_o),
    .vec_all     (vec_all),
    .vec_en_all  (vec_en_all),
    .hold_all    (hold_all)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic against a model.
module irq_aggregator_tb_top;
    localparam int NCH = 8, NREG = 4, W = 8, AW = 7;
    localparam int TOT = NCH*NREG*W;

    logic clk = 1'b0, rst_n = 1'b0, init_n = 1'b1;
    logic [TOT-1:0] evt_i = '0;
    logic cpu_we = 1'b0, cpu_re = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [W-1:0] cpu_wdata = '0;
    logic [W-1:0] cpu_rdata;
    logic irq_drive_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_aggregator #(.NCH(NCH), .NREG(NREG), .W(W)) dut_i (.*);

    // Reference model state
    logic [W-1:0]    m_st [NCH][NREG];
    logic [W-1:0]    m_mk [NCH][NREG];
    logic [NREG-1:0] m_vm [NCH];
    logic            m_run [NCH];
    logic            m_live [NCH];
    logic            m_irq;
    logic [W-1:0]    m_rd;

    function automatic logic [AW-1:0] adr(int c, int o);
        return AW'(c*16 + o);
    endfunction

    function automatic logic [TOT-1:0] ev(int c, int r, int b);
        logic [TOT-1:0] v = '0;
        v[(c*NREG+r)*W + b] = 1'b1;
        return v;
    endfunction

    function automatic logic [NREG-1:0] m_vec(int c);
        logic [NREG-1:0] v;
        for (int r = 0; r < NREG; r++) v[r] = m_run[c] && (|(m_st[c][r] & m_mk[c][r]));
        return v;
    endfunction

    function automatic logic [W-1:0] m_read(logic [AW-1:0] a);
        int c = int'(a[AW-1:4]);
        int o = int'(a[3:0]);
        if (o < NREG) return m_st[c][o];
        if (o >= 4 && o < 4 + NREG) return m_mk[c][o-4];
        if (o == 8) return W'(m_vm[c]);
        if (o == 9) return W'({m_live[c], m_run[c]});
        if (o == 10) return W'(m_vec(c));
        return '0;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < NREG; r++) begin
                m_st[c][r] = '0;
                m_mk[c][r] = '1;
            end
            m_vm[c] = '1; m_run[c] = 0; m_live[c] = 0;
        end
        m_irq = 0; m_rd = '0;
    endtask

    // One clock of stimulus with model update and per-cycle comparison
    task automatic step(logic [TOT-1:0] e, logic we, logic re, logic [AW-1:0] a, logic [W-1:0] d);
        logic [W-1:0] nst [NCH][NREG];
        logic irqn;
        logic [W-1:0] rdn;
        int ca, oa;
        @(negedge clk);
        evt_i = e; cpu_we = we; cpu_re = re; cpu_addr = a; cpu_wdata = d;
        ca = int'(a[AW-1:4]); oa = int'(a[3:0]);
        rdn = re ? m_read(a) : m_rd;
        irqn = 1'b0;
        for (int c = 0; c < NCH; c++)
            if (|(m_vec(c) & m_vm[c])) irqn = 1'b1;
        irqn = irqn && init_n;
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < NREG; r++)
                if (!init_n || !m_live[c]) nst[c][r] = '0;
                else nst[c][r] = ((re && c == ca && oa == r) ? '0 : m_st[c][r]) | e[(c*NREG+r)*W +: W];
        @(posedge clk); #1;
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < NREG; r++) m_st[c][r] = nst[c][r];
        if (we) begin
            if (oa >= 4 && oa < 4 + NREG) m_mk[ca][oa-4] = d;
            else if (oa == 8) m_vm[ca] = d[NREG-1:0];
            else if (oa == 9) begin
                if (d[2]) begin
                    for (int r = 0; r < NREG; r++) begin m_mk[ca][r] = '1; m_st[ca][r] = '0; end
                    m_vm[ca] = '1; m_run[ca] = 0; m_live[ca] = 0;
                end else begin
                    m_run[ca] = d[0]; m_live[ca] = d[1];
                end
            end
        end
        m_irq = irqn; m_rd = rdn;
        chk(irq_drive_o === m_irq, "R4 model irq", 32'(irq_drive_o), 32'(m_irq));
        if (re) chk(cpu_rdata === m_rd, "R2 model rdata", 32'(cpu_rdata), 32'(m_rd));
        evt_i = '0; cpu_we = 0; cpu_re = 0;
    endtask

    task automatic idle(); step('0, 0, 0, '0, '0); endtask
    task automatic wr(logic [AW-1:0] a, logic [W-1:0] d); step('0, 1, 0, a, d); endtask
    task automatic rd(logic [AW-1:0] a, logic [W-1:0] exp, string tag);
        step('0, 0, 1, a, '0);
        chk(cpu_rdata === exp, tag, 32'(cpu_rdata), 32'(exp));
    endtask
    task automatic irq_is(logic exp, string tag);
        chk(irq_drive_o === exp, tag, 32'(irq_drive_o), 32'(exp));
    endtask

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [TOT-1:0] e;
        void'($urandom(32'd7321));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9: reset state
        irq_is(1'b0, "R9 irq after reset");
        rd(adr(0, 5), 8'hFF, "R9 mask after reset");
        rd(adr(3, 8), 8'h0F, "R9 vmask after reset");
        rd(adr(0, 9), 8'h00, "R9 ctrl after reset");
        // R7: live=0 blocks capture
        step(ev(2, 0, 3), 0, 0, '0, '0);
        rd(adr(2, 0), 8'h00, "R7 no capture while held");
        rd(adr(2, 10), 8'h00, "R7 vector zero while held");
        // Enable all channels, R10 readback
        for (int c = 0; c < NCH; c++) wr(adr(c, 9), 8'h03);
        rd(adr(6, 9), 8'h03, "R10 ctrl readback");
        wr(adr(1, 6), 8'h5A);
        rd(adr(1, 6), 8'h5A, "R10 mask readback");
        wr(adr(1, 8), 8'h0B);
        rd(adr(1, 8), 8'h0B, "R10 vmask readback");
        wr(adr(1, 8), 8'h0F);
        // R1/R4: capture and request timing
        step(ev(3, 1, 0), 0, 0, '0, '0);
        irq_is(1'b0, "R4 not yet one edge after event");
        idle();
        irq_is(1'b1, "R4 asserted two edges after event");
        // R3: vector word, not cleared by read
        rd(adr(3, 10), 8'h02, "R3 vector word");
        rd(adr(3, 10), 8'h02, "R3 vector survives read");
        // R1/R2: read returns then clears; R4 release timing
        rd(adr(3, 1), 8'h01, "R1 status captured");
        irq_is(1'b1, "R4 still low at clearing edge");
        rd(adr(3, 1), 8'h00, "R2 cleared by read");
        irq_is(1'b0, "R4 released one edge after clear");
        // R2: event coincident with read survives
        step(ev(4, 0, 7), 0, 1, adr(4, 0), '0);
        chk(cpu_rdata === 8'h00, "R2 read before collision", 32'(cpu_rdata), 0);
        rd(adr(4, 0), 8'h80, "R2 colliding event kept");
        idle();
        // R4: two sources, line held until both cleared
        step(ev(1, 0, 2) | ev(6, 3, 6), 0, 0, '0, '0);
        idle();
        rd(adr(1, 0), 8'h04, "R1 first source");
        idle();
        irq_is(1'b1, "R4 held by second source");
        rd(adr(6, 3), 8'h40, "R1 second source");
        idle();
        irq_is(1'b0, "R4 released after all cleared");
        // R5: vector mask
        wr(adr(5, 8), 8'h0E);
        step(ev(5, 0, 1), 0, 0, '0, '0);
        idle(); idle();
        irq_is(1'b0, "R5 masked vector no request");
        rd(adr(5, 10), 8'h01, "R5 vector still reported");
        rd(adr(5, 0), 8'h02, "R5 status still captured");
        // R6: suspend
        wr(adr(0, 9), 8'h02);
        step(ev(0, 3, 4), 0, 0, '0, '0);
        idle(); idle();
        irq_is(1'b0, "R6 suspended no request");
        rd(adr(0, 10), 8'h00, "R6 vector forced zero");
        rd(adr(0, 3), 8'h10, "R6 status captured");
        rd(adr(0, 3), 8'h00, "R6 still clears on read");
        wr(adr(0, 9), 8'h03);
        // R3: per-bit mask
        wr(adr(7, 6), 8'h0F);
        step(ev(7, 2, 5), 0, 0, '0, '0);
        idle(); idle();
        irq_is(1'b0, "R3 masked bit no request");
        rd(adr(7, 10), 8'h00, "R3 masked bit no vector");
        step(ev(7, 2, 1), 0, 0, '0, '0);
        idle();
        irq_is(1'b1, "R3 unmasked bit requests");
        // R8: global init
        init_n = 1'b0;
        idle();
        irq_is(1'b0, "R8 released during init");
        step(ev(7, 2, 3), 0, 0, '0, '0);
        init_n = 1'b1;
        rd(adr(7, 2), 8'h00, "R8 status cleared and not updated");
        rd(adr(7, 6), 8'h0F, "R8 mask preserved");
        rd(adr(7, 9), 8'h03, "R8 ctrl preserved");
        // R9: channel reset
        wr(adr(7, 9), 8'h04);
        rd(adr(7, 6), 8'hFF, "R9 channel reset mask");
        rd(adr(7, 9), 8'h00, "R9 channel reset ctrl");
        rd(adr(6, 9), 8'h03, "R9 other channel untouched");
        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic [W-1:0] d;
            int kind;
            for (int w = 0; w < TOT/32; w++)
                e[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom & $urandom;
            init_n = ($urandom % 64) != 0;
            a = {3'($urandom), 4'($urandom % 11)};
            d = 8'($urandom);
            if (a[3:0] == 4'd9) begin
                d[1] = ($urandom % 8) != 0;
                if (($urandom % 16) != 0) d[2] = 1'b0;
            end
            kind = $urandom % 4;
            if (kind == 0)      step(e, 1, 0, a, d);
            else if (kind == 1) step(e, 0, 0, a, d);
            else                step(e, 0, 1, a, d);
        end
        init_n = 1'b1;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule